// File: doc/BRIEF.md
# SRAM Size Discovery Sequencer

This block finds out how much external single-port synchronous SRAM is fitted to a board. It runs a series of write-then-read-back trials over a candidate range of words. Every pass or fail result steers a binary search on the size setting. A smaller physical part decodes fewer address bits, so its upper words alias onto lower ones. The pattern written is unique to each address, which means a range larger than the real part always reads back wrong data.

The host sees a 64-bit control/status word. A write that sets the start bit launches a complete search, and a second bit selects fail-stop. The host then polls the done flag and samples the error flag. When done is set without error, the size field holds the largest tested word count that passed. The first trial always uses the smallest size. If that trial fails, the memory is reported as defective. Otherwise the next trial uses the largest size, and after that the search splits the remaining interval in half each time.

Top module: `sram_size_probe`

## Requirements
- R1: After reset the status word reads all zero and the SRAM write enable is low. The write enable is never high while the search is idle.
- R2: A host write with bit 61 set while idle starts a search. In the next cycle busy (bit 60) reads 1 and done reads 0. Bit 59 of the same write enables fail-stop, so the byte value 0x28 in bits 63:56 starts a search with fail-stop.
- R3: A host write with bit 61 clear changes no status bit, no size field and no SRAM activity, whatever the other 63 bits hold.
- R4: If the first trial, which uses MIN_SIZE words, fails, the search ends with done (bit 63) = 1, error (bit 62) = 1 and a size of 0.
- R5: If the MIN_SIZE trial passes, the second trial uses MAX_SIZE words. If that passes, the reported size is MAX_SIZE.
- R6: The search keeps a lower bound (last pass) and an upper bound (last fail). Each later trial size is the bounds' mean rounded down to a multiple of MIN_SIZE. The search ends when the bounds differ by MIN_SIZE or less and reports the lower bound. That value is the largest multiple of MIN_SIZE not above the fitted word count.
- R7: Status layout: bit 63 done, bit 62 error, bit 60 busy, bits 31:0 size. Done and busy are never both set. Error is only set together with done. The size field reads 0 while busy.
- R8: A start write while busy is ignored. The running search continues unchanged, with no extra or restarted trial.
- R9: Each trial writes addresses 0 to size-1 in ascending order with data equal to the address XOR SEED (truncated to DATA_W), then reads the same range back.
- R10: With fail-stop clear, each read pass covers its whole range and the search gives the same sizes and result as with fail-stop set.
- R11: The sequence of trial sizes is exactly MIN_SIZE, then MAX_SIZE, then the R6 midpoints. No other trial is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Host write strobe for the control word |
| ctrlWdata | input | 64 | Host write data; only bits 61 and 59 are used |
| ctrlRdata | output | 64 | Status word: done, error, busy, size |
| sramAddr | output | ADDR_W | SRAM word address |
| sramWdata | output | DATA_W | SRAM write data |
| sramWe | output | 1 | SRAM write enable |
| sramRdata | input | DATA_W | SRAM read data, valid one cycle after the address |

## Verification
A wrong bound or a bad midpoint shows up at the start of the next write pass as a trial length the bench did not expect. A wrong trial order shows up the same way. A corrupted compare or a lost failure flag moves a bound in the wrong direction, so the trial after it has the wrong size and the final size field is wrong when done rises. A sequencer that restarts on a start write during a search issues an extra MIN_SIZE write pass within a few cycles. Broken flag handling breaks the done, busy and error relations in the status word within one cycle.

// File: rtl/sram_size_probe_pkg.sv
package sram_size_probe_pkg;

  // strobes from the search control to the pattern datapath
  typedef struct packed {
    logic clearAddr;
    logic stepAddr;
    logic writeEn;
    logic readEn;
    logic clearFail;
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DRAIN,
    ST_DECIDE
  } seqState_t;

  typedef enum logic [1:0] {
    PH_MIN,
    PH_MAX,
    PH_BIN
  } searchPhase_t;

endpackage

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import sram_size_probe_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int SIZE_W = 16,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [SIZE_W-1:0] trialSize,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWdata,
  output logic              sramWe,
  input  logic [DATA_W-1:0] sramRdata,
  output logic              lastAddr,
  output logic              failSeen
);

  logic [ADDR_W-1:0] addrCnt;
  logic [ADDR_W-1:0] readAddrQ;
  logic              readValid;
  logic              failQ;

  function automatic logic [DATA_W-1:0] patternOf(input logic [ADDR_W-1:0] a);
    return DATA_W'(a) ^ SEED;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt   <= '0;
      readAddrQ <= '0;
      readValid <= 1'b0;
      failQ     <= 1'b0;
    end else begin
      if (cmd.clearAddr)     addrCnt <= '0;
      else if (cmd.stepAddr) addrCnt <= addrCnt + 1'b1;
      readValid <= cmd.readEn;
      readAddrQ <= addrCnt;
      // read data returns one cycle after the address
      if (cmd.clearFail)
        failQ <= 1'b0;
      else if (readValid && (sramRdata != patternOf(readAddrQ)))
        failQ <= 1'b1;
    end
  end

  assign sramAddr  = addrCnt;
  assign sramWdata = patternOf(addrCnt);
  assign sramWe    = cmd.writeEn;
  assign lastAddr  = ({1'b0, addrCnt} == (trialSize - SIZE_W'(1)));
  assign failSeen  = failQ;

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import sram_size_probe_pkg::*;
#(
  parameter int MIN_SIZE = 4,
  parameter int MAX_SIZE = 32768,
  parameter int SIZE_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              failStopReq,
  input  logic              lastAddr,
  input  logic              failSeen,
  output dpCmd_t            cmd,
  output logic [SIZE_W-1:0] trialSize,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [SIZE_W-1:0] resultSize
);

  localparam logic [SIZE_W-1:0] MIN_V      = SIZE_W'(MIN_SIZE);
  localparam logic [SIZE_W-1:0] MAX_V      = SIZE_W'(MAX_SIZE);
  localparam logic [SIZE_W-1:0] ALIGN_MASK = ~(MIN_V - SIZE_W'(1));

  seqState_t         stateQ;
  searchPhase_t      phaseQ;
  logic [SIZE_W-1:0] lowQ, highQ, trialQ, resultQ;
  logic              failStopQ, busyQ, doneQ, errorQ;

  logic [SIZE_W-1:0] nextLow, nextHigh, midPoint;
  logic [SIZE_W:0]   boundSum;
  logic              searchOver;

  // bound update from the trial just finished
  always_comb begin
    nextLow  = lowQ;
    nextHigh = highQ;
    if (failSeen) nextHigh = trialQ;
    else          nextLow  = trialQ;
    boundSum   = {1'b0, nextLow} + {1'b0, nextHigh};
    midPoint   = boundSum[SIZE_W:1] & ALIGN_MASK;
    searchOver = (nextHigh - nextLow) <= MIN_V;
  end

  always_comb begin
    cmd = '0;
    unique case (stateQ)
      ST_IDLE: begin
        cmd.clearAddr = 1'b1;
        cmd.clearFail = 1'b1;
      end
      ST_WRITE: begin
        cmd.writeEn = 1'b1;
        if (lastAddr) cmd.clearAddr = 1'b1;
        else          cmd.stepAddr  = 1'b1;
      end
      ST_READ: begin
        cmd.readEn   = 1'b1;
        cmd.stepAddr = 1'b1;
      end
      ST_DRAIN: ;
      ST_DECIDE: begin
        cmd.clearAddr = 1'b1;
        cmd.clearFail = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      phaseQ    <= PH_MIN;
      lowQ      <= '0;
      highQ     <= '0;
      trialQ    <= MIN_V;
      resultQ   <= '0;
      failStopQ <= 1'b0;
      busyQ     <= 1'b0;
      doneQ     <= 1'b0;
      errorQ    <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startReq) begin
            trialQ    <= MIN_V;
            phaseQ    <= PH_MIN;
            lowQ      <= '0;
            highQ     <= MAX_V;
            failStopQ <= failStopReq;
            busyQ     <= 1'b1;
            doneQ     <= 1'b0;
            errorQ    <= 1'b0;
            resultQ   <= '0;
            stateQ    <= ST_WRITE;
          end
        end
        ST_WRITE: if (lastAddr) stateQ <= ST_READ;
        ST_READ: begin
          if (failStopQ && failSeen) stateQ <= ST_DECIDE;
          else if (lastAddr)         stateQ <= ST_DRAIN;
        end
        ST_DRAIN: stateQ <= ST_DECIDE;
        ST_DECIDE: begin
          if (phaseQ == PH_MIN && failSeen) begin
            busyQ  <= 1'b0;
            doneQ  <= 1'b1;
            errorQ <= 1'b1;
            stateQ <= ST_IDLE;
          end else if (phaseQ == PH_MIN) begin
            lowQ   <= MIN_V;
            trialQ <= MAX_V;
            phaseQ <= PH_MAX;
            stateQ <= ST_WRITE;
          end else if (phaseQ == PH_MAX && !failSeen) begin
            resultQ <= MAX_V;
            busyQ   <= 1'b0;
            doneQ   <= 1'b1;
            stateQ  <= ST_IDLE;
          end else begin
            lowQ  <= nextLow;
            highQ <= nextHigh;
            if (searchOver) begin
              resultQ <= nextLow;
              busyQ   <= 1'b0;
              doneQ   <= 1'b1;
              stateQ  <= ST_IDLE;
            end else begin
              trialQ <= midPoint;
              phaseQ <= PH_BIN;
              stateQ <= ST_WRITE;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign trialSize  = trialQ;
  assign busy       = busyQ;
  assign done       = doneQ;
  assign error      = errorQ;
  assign resultSize = resultQ;

endmodule

// File: rtl/sram_size_probe.sv
module sram_size_probe
  import sram_size_probe_pkg::*;
#(
  parameter int MIN_SIZE = 4,
  parameter int MAX_SIZE = 32768,
  parameter int DATA_W   = 16,
  parameter logic [DATA_W-1:0] SEED = DATA_W'(16'h5A3C),
  localparam int ADDR_W  = $clog2(MAX_SIZE),
  localparam int SIZE_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [63:0]       ctrlWdata,
  output logic [63:0]       ctrlRdata,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWdata,
  output logic              sramWe,
  input  logic [DATA_W-1:0] sramRdata
);

  localparam int DONE_BIT  = 63;
  localparam int ERROR_BIT = 62;
  localparam int START_BIT = 61;
  localparam int BUSY_BIT  = 60;
  localparam int STOP_BIT  = 59;

  dpCmd_t            cmd;
  logic [SIZE_W-1:0] trialSize, resultSize;
  logic              lastAddr, failSeen, busy, done, error;
  logic              unusedWdata;

  assign unusedWdata = ^{ctrlWdata[63:62], ctrlWdata[60], ctrlWdata[58:0]};

  ssp_ctrl #(
    .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE), .SIZE_W(SIZE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .startReq(ctrlWe && ctrlWdata[START_BIT]),
    .failStopReq(ctrlWdata[STOP_BIT]),
    .lastAddr(lastAddr), .failSeen(failSeen),
    .cmd(cmd), .trialSize(trialSize),
    .busy(busy), .done(done), .error(error), .resultSize(resultSize)
  );

  ssp_datapath #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .SEED(SEED)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .trialSize(trialSize),
    .sramAddr(sramAddr), .sramWdata(sramWdata), .sramWe(sramWe),
    .sramRdata(sramRdata), .lastAddr(lastAddr), .failSeen(failSeen)
  );

  always_comb begin
    ctrlRdata            = '0;
    ctrlRdata[DONE_BIT]  = done;
    ctrlRdata[ERROR_BIT] = error;
    ctrlRdata[BUSY_BIT]  = busy;
    ctrlRdata[31:0]      = 32'(resultSize);
  end

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int MIN_SIZE = 4,
  parameter int MAX_SIZE = 32768
) (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlWe,
  input logic [63:0] ctrlWdata,
  input logic [63:0] ctrlRdata,
  input logic        sramWe
);

  logic        done, error, busy, startWr;
  logic [31:0] sizeField;

  assign done      = ctrlRdata[63];
  assign error     = ctrlRdata[62];
  assign busy      = ctrlRdata[60];
  assign sizeField = ctrlRdata[31:0];
  assign startWr   = ctrlWe && ctrlWdata[61];

  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sramWe);

  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startWr));

  a_r4_error_means_done: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  a_r7_done_busy_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  a_r7_size_zero_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (sizeField == 32'd0));

  a_r6_result_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (done && !error) |-> (sizeField >= 32'(MIN_SIZE)) && (sizeField <= 32'(MAX_SIZE))
                          && ((sizeField & 32'(MIN_SIZE - 1)) == 32'd0));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startWr) |=> (busy || done));

endmodule

bind sram_size_probe ssp_checker #(
  .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE)
) chk_i (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
  .ctrlRdata(ctrlRdata), .sramWe(sramWe)
);

// File: tb/sram_size_probe_tb_top.sv
module sram_size_probe_tb_top;

  localparam int MIN = 4;
  localparam int MAX = 256;
  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam logic [DW-1:0] SEED = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctrlWe = 1'b0;
  logic [63:0]   ctrlWdata = '0;
  logic [63:0]   ctrlRdata;
  logic [AW-1:0] sramAddr;
  logic [DW-1:0] sramWdata;
  logic [DW-1:0] sramRdata;
  logic          sramWe;

  always #4 clk = ~clk;

  sram_size_probe #(.MIN_SIZE(MIN), .MAX_SIZE(MAX), .DATA_W(DW), .SEED(SEED)) dut_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .sramAddr(sramAddr), .sramWdata(sramWdata),
    .sramWe(sramWe), .sramRdata(sramRdata)
  );

  // physical part of physSize words: upper addresses alias onto lower ones
  int            physSize = MAX;
  logic [DW-1:0] mem [0:MAX-1];

  initial for (int i = 0; i < MAX; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (sramWe) mem[int'(sramAddr) % physSize] <= sramWdata;
    sramRdata <= mem[int'(sramAddr) % physSize];
  end

  int checks = 0;
  int errors = 0;
  int expTrials[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pattern of every write and length of every write pass
  int   burstLen = 0;
  logic prevWe = 1'b0;
  always @(negedge clk) begin
    if (rstN && sramWe) begin
      check(sramWdata == (DW'(sramAddr) ^ SEED), "R9", "write pattern", sramWdata,
            DW'(sramAddr) ^ SEED);
      check(int'(sramAddr) == burstLen, "R9", "ascending address", sramAddr, burstLen);
      burstLen++;
    end else if (prevWe) begin
      if (expTrials.size() == 0) begin
        check(1'b0, "R11", "unexpected trial", burstLen, 0);
      end else begin
        int e;
        e = expTrials.pop_front();
        check(burstLen == e, "R11", "trial size", burstLen, e);
      end
      burstLen = 0;
    end
    prevWe = sramWe;
  end

  // requirement-level prediction of trial sizes and outcome
  task automatic planSearch(input int phys, output int res, output bit err);
    int lo, hi, t;
    err = 1'b0;
    res = 0;
    expTrials.push_back(MIN);
    if (MIN > phys) begin err = 1'b1; return; end
    lo = MIN;
    expTrials.push_back(MAX);
    if (MAX <= phys) begin res = MAX; return; end
    hi = MAX;
    while (hi - lo > MIN) begin
      t = ((lo + hi) / 2) / MIN * MIN;
      expTrials.push_back(t);
      if (t <= phys) lo = t; else hi = t;
    end
    res = lo;
  endtask

  task automatic hostWrite(input logic [63:0] d);
    ctrlWdata = d;
    ctrlWe    = 1'b1;
    @(negedge clk);
    ctrlWe    = 1'b0;
  endtask

  task automatic startSearch(input bit fs);
    hostWrite({2'b00, 1'b1, 1'b0, fs, 3'b000, 56'h00DE_ADBE_EF01_23});
    check(ctrlRdata[60] == 1'b1, "R2", "busy after start", ctrlRdata[60], 1);
    check(ctrlRdata[63] == 1'b0, "R2", "done cleared on start", ctrlRdata[63], 0);
  endtask

  task automatic finishSearch(input int expRes, input bit expErr, input string req);
    while (!ctrlRdata[63]) @(negedge clk);
    check(ctrlRdata[62] == expErr, req, "error flag", ctrlRdata[62], expErr);
    check(ctrlRdata[31:0] == 32'(expRes), req, "reported size", ctrlRdata[31:0], expRes);
    check(ctrlRdata[60] == 1'b0, "R7", "busy clear at done", ctrlRdata[60], 0);
    check(expTrials.size() == 0, "R11", "trials left over", expTrials.size(), 0);
  endtask

  task automatic runSearch(input int phys, input bit fs, input string req);
    int res;
    bit err;
    physSize = phys;
    planSearch(phys, res, err);
    startSearch(fs);
    finishSearch(res, err, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] snap;
    int res;
    bit err;
    repeat (3) @(negedge clk);
    check(ctrlRdata == 64'd0, "R1", "status after reset", ctrlRdata, 0);
    check(sramWe == 1'b0, "R1", "write enable after reset", sramWe, 0);
    rstN = 1'b1;
    @(negedge clk);

    runSearch(40, 1'b1, "R6");      // midpoint search, exact multiple
    runSearch(MAX, 1'b1, "R5");     // full part fitted
    runSearch(2, 1'b1, "R4");       // smaller than minimum: defective
    runSearch(129, 1'b0, "R10");    // no fail-stop, rounds down to 128
    runSearch(7, 1'b1, "R6");       // lands on the minimum step
    runSearch(255, 1'b0, "R10");    // no fail-stop, rounds down to 252

    // R8: a start while busy is ignored
    physSize = 40;
    planSearch(40, res, err);
    startSearch(1'b1);
    repeat (50) @(negedge clk);
    hostWrite({8'h28, 56'h0});
    check(ctrlRdata[60] == 1'b1, "R8", "busy kept after second start", ctrlRdata[60], 1);
    check(ctrlRdata[63] == 1'b0, "R8", "done still clear", ctrlRdata[63], 0);
    finishSearch(res, err, "R8");

    // R3: writes without the start bit change nothing
    snap = ctrlRdata;
    hostWrite(64'hD7FF_FFFF_FFFF_FFFF);
    hostWrite({8'h08, 56'hFF_FFFF_FFFF_FFFF});
    for (int k = 0; k < 5; k++) begin
      check(ctrlRdata == snap, "R3", "status unchanged", ctrlRdata[31:0], snap[31:0]);
      check(sramWe == 1'b0, "R3", "no SRAM write", sramWe, 0);
      @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule